// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder, plus an optional index signal, into a signed 16-bit position count. All three inputs are brought into the clock domain by flop synchronisers. The phase pair can optionally pass through a glitch filter that accepts a new level only once it has held steady.

The decoder tracks the four-state Gray position of the phase pair. Each single step moves the count up or down, depending on the direction of the step. A selectable resolution thins the counting to one, two or four counts per full electrical cycle. A jump of two states at once cannot be decoded, so it leaves the count alone and is reported as an invalid event.

Four event kinds are each latched into their own bit of a sticky status word: counter wrap upward, counter wrap downward, index reset and invalid step. One interrupt line is raised while any of those bits is set. A read strobe clears the word, but an event that lands in the same cycle as the read survives it.

Top module: `qenc_counter`

## Requirements
- R1: After reset, `count_o` is 0, `status_o` is 0 and `irq_o` is low.
- R2: The phase pair {A,B} encodes positions in cyclic order 00→01→11→10→00. A step one place forward in this order increments the count, and a step backward decrements it (at 4x resolution).
- R3: With `res_sel_i` = 0 (1x), only steps between position 00 and position 01 change the count, giving one count per full cycle.
- R4: With `res_sel_i` = 1 (2x), only steps between 00 and 01 and steps between 11 and 10 change the count, giving two counts per cycle.
- R5: A change of both phase bits in one sample (a jump of two positions) leaves the count unchanged and sets `status_o[3]`.
- R6: Incrementing from 32767 gives -32768 and sets `status_o[0]`.
- R7: Decrementing from -32768 gives 32767 and sets `status_o[1]`.
- R8: When `index_en_i` is high, a rising edge on the synchronised index sets the count to 0 and sets `status_o[2]`. This takes priority over a count step in the same cycle, and no wrap event is raised for that step. When `index_en_i` is low, the index input has no effect.
- R9: Status bits are sticky. A cycle with `stat_rd_i` high clears them at the next edge, except for any bit whose event occurs in that same cycle, which stays set.
- R10: `irq_o` is high exactly when at least one status bit is set.
- R11: With the filter off, a phase change on the inputs shows up on `count_o` after the third rising clock edge that follows it.
- R12: With `filt_en_i` high, a new phase level is taken only after three consecutive identical synchronised samples. A level held for only two samples is ignored.
- R13: `res_sel_i` = 3 counts like 4x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| index_i | input | 1 | Encoder index, asynchronous |
| index_en_i | input | 1 | Enables zeroing of the count on an index rising edge |
| filt_en_i | input | 1 | Enables the three-sample glitch filter on the phase pair |
| res_sel_i | input | 2 | Resolution: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| stat_rd_i | input | 1 | Status read strobe; clears the sticky bits |
| count_o | output | 16 | Signed position count |
| status_o | output | 4 | Sticky events: [0] up-wrap, [1] down-wrap, [2] index, [3] invalid |
| irq_o | output | 1 | High while any status bit is set |

## Verification
The bench walks the phase pair forward and backward one position at a time at each resolution. Full-cycle sweeps separate 1x from 2x from 4x counting, and a reversal shows that the direction logic is symmetric. Two-position jumps are driven to tell an undecodable step apart from a legal one. Index pulses are driven with the enable low, with the enable high, and together with a phase step, which exposes priority between zeroing and counting. Short and longer phase pulses with the filter on separate accepted levels from rejected glitches. A long one-step-per-cycle run drives the count through both wrap points.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  // Resolution selection as presented on res_sel_i
  typedef enum logic [1:0] {
    RES_X1  = 2'd0,
    RES_X2  = 2'd1,
    RES_X4  = 2'd2,
    RES_X4A = 2'd3
  } res_e;

  localparam int EV_W = 4;

  // Event vector; packed so that bit 0 is the up-wrap event
  typedef struct packed {
    logic inv;
    logic idx;
    logic unf;
    logic ovf;
  } ev_t;

  // Position of a Gray-coded phase pair {A,B} in the cycle
  function automatic logic [1:0] phase_ord(input logic [1:0] ab);
    logic [1:0] p;
    case (ab)
      2'b00:   p = 2'd0;
      2'b01:   p = 2'd1;
      2'b11:   p = 2'd2;
      default: p = 2'd3;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/qenc_glitch.sv
module qenc_glitch #(
  parameter int LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic en_i,
  output logic q_o
);

  localparam int HW = LEN - 1;

  logic [HW-1:0] hist_q, hist_d;
  logic          acc_q;
  logic          steady, acc_en;

  always_comb begin
    hist_d[0] = d_i;
    for (int i = 1; i < HW; i++) hist_d[i] = hist_q[i-1];
    steady = (hist_q == {HW{d_i}});
    acc_en = steady && (acc_q != d_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= 1'b0;
    else if (acc_en) acc_q <= d_i;
  end

  assign q_o = en_i ? acc_q : d_i;

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lvl_i,
  input  res_e       res_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       inv_o
);

  logic [1:0] st_q;
  logic [1:0] p_old, p_new, dlt, edge_id;
  logic       sel, st_en;

  always_comb begin
    p_old   = phase_ord(st_q);
    p_new   = phase_ord(lvl_i);
    dlt     = p_new - p_old;
    // edge k joins position k and position k+1
    edge_id = (dlt == 2'd1) ? p_old : p_new;
    case (res_i)
      RES_X1:  sel = (edge_id == 2'd0);
      RES_X2:  sel = ~edge_id[0];
      default: sel = 1'b1;
    endcase
    up_o  = (dlt == 2'd1) && sel;
    dn_o  = (dlt == 2'd3) && sel;
    inv_o = (dlt == 2'd2);
    st_en = (lvl_i != st_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= 2'b00;
    else if (st_en) st_q <= lvl_i;
  end

endmodule

// File: rtl/qenc_count.sv
module qenc_count
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                up_i,
  input  logic                dn_i,
  input  logic                inv_i,
  input  logic                idx_i,
  output logic signed [W-1:0] count_o,
  output ev_t                 ev_o
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ev_o   = '0;
    ev_o.inv = inv_i;
    if (idx_i) begin
      cnt_d    = '0;
      cnt_en   = 1'b1;
      ev_o.idx = 1'b1;
    end else if (up_i) begin
      cnt_d    = cnt_q + 1'b1;
      cnt_en   = 1'b1;
      ev_o.ovf = (cnt_q == MAXV);
    end else if (dn_i) begin
      cnt_d    = cnt_q - 1'b1;
      cnt_en   = 1'b1;
      ev_o.unf = (cnt_q == MINV);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = $signed(cnt_q);

endmodule

// File: rtl/qenc_status.sv
module qenc_status
  import qenc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ev_t             ev_i,
  input  logic            rd_i,
  output logic [EV_W-1:0] stat_o
);

  logic [EV_W-1:0] stat_q, stat_d;
  logic            stat_en;

  always_comb begin
    stat_en = rd_i || (ev_i != '0);
    stat_d  = (rd_i ? '0 : stat_q) | ev_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    phase_a_i,
  input  logic                    phase_b_i,
  input  logic                    index_i,
  input  logic                    index_en_i,
  input  logic                    filt_en_i,
  input  logic [1:0]              res_sel_i,
  input  logic                    stat_rd_i,
  output logic signed [CNT_W-1:0] count_o,
  output logic [EV_W-1:0]         status_o,
  output logic                    irq_o
);

  localparam int PH_W = 2;
  localparam int IN_W = PH_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // input synchronisers: {index, A, B}
  logic [IN_W-1:0] raw_in, syn_in;
  assign raw_in = {index_i, phase_a_i, phase_b_i};

  qenc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (raw_in),
    .q_o    (syn_in)
  );

  // optional glitch filter per phase
  logic [PH_W-1:0] phase_lvl;

  for (genvar g = 0; g < PH_W; g++) begin : g_filt
    qenc_glitch #(.LEN(FILT_LEN)) u_glitch (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .d_i    (syn_in[g]),
      .en_i   (filt_en_i),
      .q_o    (phase_lvl[g])
    );
  end

  // index rising edge
  logic idx_q, idx_hit;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) idx_q <= 1'b0;
    else        idx_q <= syn_in[PH_W];
  end
  assign idx_hit = index_en_i && syn_in[PH_W] && !idx_q;

  // decode, count, status
  logic step_up, step_dn, step_inv;
  ev_t  ev_s;

  qenc_decode u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lvl_i  (phase_lvl),
    .res_i  (res_e'(res_sel_i)),
    .up_o   (step_up),
    .dn_o   (step_dn),
    .inv_o  (step_inv)
  );

  qenc_count #(.W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .up_i    (step_up),
    .dn_i    (step_dn),
    .inv_i   (step_inv),
    .idx_i   (idx_hit),
    .count_o (count_o),
    .ev_o    (ev_s)
  );

  qenc_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .ev_i   (ev_s),
    .rd_i   (stat_rd_i),
    .stat_o (status_o)
  );

  assign irq_o = |status_o;

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic signed [W-1:0] count_o,
  input logic [3:0]          status_o,
  input logic                stat_rd_i,
  input logic [3:0]          ev_bus,
  input logic                inv_ev,
  input logic                idx_ev
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // R5
  invalid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_ev && !idx_ev |=> count_o == $past(count_o));

  // R8
  index_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_ev |=> count_o == '0);

  // R6
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> count_o == MINV);

  // R7
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> count_o == MAXV);

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> (status_o & $past(status_o)) == $past(status_o));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && ev_bus == 4'b0000 |=> status_o == 4'b0000);

endmodule

bind qenc_counter qenc_counter_chk #(.W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_o   (count_o),
  .status_o  (status_o),
  .stat_rd_i (stat_rd_i),
  .ev_bus    (ev_s),
  .inv_ev    (ev_s.inv),
  .idx_ev    (ev_s.idx)
);

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, a, b, idx, idx_en, filt_en, rd;
  logic [1:0] res;
  logic signed [15:0] count;
  logic [3:0] status;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit cmp_en = 0;
  bit done = 0;
  int pos = 0;
  int expc = 0;

  qenc_counter u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .phase_a_i  (a),
    .phase_b_i  (b),
    .index_i    (idx),
    .index_en_i (idx_en),
    .filt_en_i  (filt_en),
    .res_sel_i  (res),
    .stat_rd_i  (rd),
    .count_o    (count),
    .status_o   (status),
    .irq_o      (irq)
  );

  function automatic logic [1:0] gray(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int place(input logic [1:0] ab);
    for (int p = 0; p < 4; p++) if (gray(p) == ab) return p;
    return 0;
  endfunction

  // behavioural reference: history of raw samples, newest first
  logic [2:0] raw_q[$];
  int m_cnt;
  logic [3:0] m_stat;
  logic [1:0] m_acc, m_lvl;

  always @(posedge clk) begin
    if (!rst_ni) begin
      raw_q.delete();
      for (int i = 0; i < 8; i++) raw_q.push_front(3'b000);
      m_cnt = 0; m_stat = 4'h0; m_acc = 2'b00; m_lvl = 2'b00;
    end else begin
      logic [1:0] lvl;
      logic [3:0] ev;
      int dl, eid;
      bit up, dn, take, hit;
      raw_q.push_front({idx, a, b});
      void'(raw_q.pop_back());
      lvl = filt_en ? m_acc : raw_q[2][1:0];
      if (raw_q[2][1:0] == raw_q[3][1:0] && raw_q[3][1:0] == raw_q[4][1:0])
        m_acc = raw_q[2][1:0];
      dl  = (place(lvl) - place(m_lvl) + 4) % 4;
      eid = (dl == 1) ? place(m_lvl) : place(lvl);
      if (res == 2'd0)      take = (eid == 0);
      else if (res == 2'd1) take = (eid % 2 == 0);
      else                  take = 1;
      up  = (dl == 1) && take;
      dn  = (dl == 3) && take;
      hit = idx_en && raw_q[2][2] && !raw_q[3][2];
      ev  = 4'h0;
      ev[3] = (dl == 2);
      if (hit) begin
        m_cnt = 0; ev[2] = 1;
      end else if (up) begin
        if (m_cnt == 32767) begin m_cnt = -32768; ev[0] = 1; end
        else m_cnt = m_cnt + 1;
      end else if (dn) begin
        if (m_cnt == -32768) begin m_cnt = 32767; ev[1] = 1; end
        else m_cnt = m_cnt - 1;
      end
      m_stat = (rd ? 4'h0 : m_stat) | ev;
      m_lvl  = lvl;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_en) begin
      vectors++;
      if (int'(count) != m_cnt || status !== m_stat || irq !== (m_stat != 4'h0)) begin
        miscompares++;
        $display("FAIL %s: actual cnt=%0d st=%h irq=%b expected cnt=%0d st=%h irq=%b",
                 cur_req, count, status, irq, m_cnt, m_stat, (m_stat != 4'h0));
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int dir);
    @(posedge clk); #2;
    pos = (pos + dir + 4) % 4;
    {a, b} = gray(pos);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic settle();
    idle(10);
    @(negedge clk);
  endtask

  task automatic read_status();
    @(posedge clk); #2 rd = 1'b1;
    @(posedge clk); #2 rd = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 0; a = 0; b = 0; idx = 0; idx_en = 0; filt_en = 0; rd = 0; res = 2'd2;
    idle(4); #2 rst_ni = 1;
    idle(4);
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    cmp_en = 1;

    // R2 forward then backward at 4x
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin step(1); idle(3); end
    settle(); expc = 8;
    chk("R2 forward", count, expc);
    for (int i = 0; i < 3; i++) begin step(-1); idle(3); end
    settle(); expc = 5;
    chk("R2 backward", count, expc);

    // R11 latency of one step
    cur_req = "R11";
    step(1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R11 before third edge", count, expc);
    @(negedge clk);
    expc++;
    chk("R11 after third edge", count, expc);

    // R3 1x: two full forward cycles, then one back
    cur_req = "R3"; settle(); res = 2'd0;
    for (int i = 0; i < 8; i++) step(1);
    settle(); expc += 2;
    chk("R3 1x forward", count, expc);
    for (int i = 0; i < 4; i++) step(-1);
    settle(); expc -= 1;
    chk("R3 1x backward", count, expc);

    // R4 2x
    cur_req = "R4"; res = 2'd1;
    for (int i = 0; i < 8; i++) step(1);
    settle(); expc += 4;
    chk("R4 2x forward", count, expc);

    // R13 code 3 acts as 4x
    cur_req = "R13"; res = 2'd3;
    for (int i = 0; i < 4; i++) step(1);
    settle(); expc += 4;
    chk("R13 4x alias", count, expc);

    // R5 invalid jump
    cur_req = "R5"; res = 2'd2;
    step(2);
    settle();
    chk("R5 count held", count, expc);
    chk("R5 invalid bit", status[3], 1);
    chk("R10 irq set", irq, 1);
    cur_req = "R9";
    read_status(); settle();
    chk("R9 cleared", status, 0);
    chk("R10 irq clear", irq, 0);

    // R8 index ignored when disabled
    cur_req = "R8";
    @(posedge clk); #2 idx = 1; idle(2); #2 idx = 0;
    settle();
    chk("R8 disabled count", count, expc);
    chk("R8 disabled status", status, 0);
    idx_en = 1;
    @(posedge clk); #2 idx = 1; idle(2); #2 idx = 0;
    settle(); expc = 0;
    chk("R8 index zero", count, 0);
    chk("R8 index bit", status, 4'b0100);
    for (int i = 0; i < 3; i++) begin step(1); idle(2); end
    settle(); expc = 3;
    chk("R8 count before", count, expc);
    read_status();
    @(posedge clk); #2 idx = 1; pos = (pos + 1) % 4; {a, b} = gray(pos);
    idle(2); #2 idx = 0;
    settle(); expc = 0;
    chk("R8 priority count", count, 0);
    chk("R8 priority status", status, 4'b0100);

    // R9 event in the read cycle survives
    cur_req = "R9";
    step(2);
    idle(2); #2 rd = 1'b1;
    @(posedge clk); #2 rd = 1'b0;
    settle();
    chk("R9 coincident", status, 4'b1000);
    read_status(); settle();

    // R12 glitch filter
    cur_req = "R12"; filt_en = 1;
    step(1); idle(1); step(-1);
    settle();
    chk("R12 short pulse", count, expc);
    step(1); settle(); expc++;
    chk("R12 steady level", count, expc);
    step(1); idle(2); step(-1);
    settle();
    chk("R12 three-sample pulse net", count, expc);
    filt_en = 0;
    settle();

    // R6 up-wrap
    cur_req = "R6";
    for (int i = expc; i < 32767; i++) step(1);
    settle(); expc = 32767;
    chk("R6 at maximum", count, expc);
    step(1); settle();
    chk("R6 wrapped", count, -32768);
    chk("R6 status", status, 4'b0001);

    // R7 down-wrap
    cur_req = "R7";
    read_status();
    step(-1); settle();
    chk("R7 wrapped", count, 32767);
    chk("R7 status", status, 4'b0010);
    cur_req = "R10";
    read_status(); settle();
    chk("R10 irq low", irq, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule